// File: doc/BRIEF.md
# Memory Clock Stop Sequencer

This block is part of a memory controller. It orders the steps that stop and restart the memory clock around a deep power-down state. A power-down request from the controller makes the block issue a one-cycle power-down command strobe. After a programmable delay, the block raises a clock-stop signal and drops the clock enable. This parks the memory clock at a static high level. A wake request lowers the clock-stop signal and turns the clock back on. After the same programmable delay, the block issues a one-cycle recover command strobe.

The delay is an 8-bit cycle count. It sits in a small holding register, which resets to 15 and is loaded through a write strobe. The block captures the count when each phase begins, the entry phase and the exit phase separately. A write made in the middle of a phase therefore does not change the phase already running. A busy flag marks the whole excursion, from the power-down command through the recover command.

Top module: `mclk_stop_seq`

## Requirements
- R1: While reset is applied and directly after it, the block is running: clk_en_o=1, clk_stop_o=0, busy_o=0, pd_cmd_o=0 and rec_cmd_o=0.
- R2: A pd_req_i sampled high while running makes pd_cmd_o high for exactly one cycle, starting in the cycle after that clock edge.
- R3: clk_stop_o rises exactly N cycles after the cycle in which pd_cmd_o is high, where N is the captured count. With N=0 it rises in the same cycle as pd_cmd_o.
- R4: clk_en_o is 0 in every cycle in which clk_stop_o is 1, so the clock is parked high, and clk_en_o is 1 in every other cycle.
- R5: A wake_req_i sampled high while the clock is parked makes clk_stop_o fall in the next cycle. rec_cmd_o is then high for exactly one cycle, N cycles after the fall, or in the same cycle when N=0.
- R6: A wake_req_i sampled during the entry delay is held. It is acted on at the first clock edge after clk_stop_o has risen, so clk_stop_o stays high for exactly one cycle.
- R7: The count is an 8-bit unsigned number of cycles, from 0 to 255, and the holding register resets to 15.
- R8: cfg_we_i loads cfg_len_i into the holding register at the clock edge. A sequence captures the value held before that edge when it starts, on either the power-down or the wake request, and later writes do not change the phase already running.
- R9: busy_o is high from the cycle of pd_cmd_o through the cycle of rec_cmd_o inclusive, and low in the cycle after rec_cmd_o.
- R10: pd_req_i is ignored unless the block is running. wake_req_i is ignored while the block is running or in the exit delay. When both requests are high while running, the power-down request is taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pd_req_i | input | 1 | Request to enter deep power-down |
| wake_req_i | input | 1 | Request to leave deep power-down |
| cfg_we_i | input | 1 | Write strobe for the delay count |
| cfg_len_i | input | 8 | New delay count in cycles |
| pd_cmd_o | output | 1 | One-cycle power-down command strobe |
| rec_cmd_o | output | 1 | One-cycle recover command strobe |
| clk_stop_o | output | 1 | High while the memory clock is stopped |
| clk_en_o | output | 1 | Memory clock enable, low parks the clock high |
| busy_o | output | 1 | High during a power-down excursion |

## Verification
Every output is a register. pd_cmd_o and busy_o therefore change in the cycle after the edge that samples a power-down request, and clk_stop_o follows N cycles later. clk_stop_o falls in the cycle after an accepted wake, and rec_cmd_o comes N cycles after that fall. The bench drives inputs on the falling edge. At the next falling edge it compares every output with a cycle model, which advances once per rising edge from the same inputs. A separate directed check counts the cycles from pd_cmd_o to clk_stop_o after reset, to confirm the count of 15.

// File: rtl/mcs_pkg.sv
package mcs_pkg;

    typedef enum logic [1:0] {
        ST_RUN    = 2'd0,
        ST_ENTRY  = 2'd1,
        ST_PARKED = 2'd2,
        ST_EXIT   = 2'd3
    } seq_state_e;

    typedef struct packed {
        seq_state_e st;
        logic       wake_pend;
        logic       pd_cmd;
        logic       rec_cmd;
        logic       clk_stop;
        logic       clk_en;
        logic       busy;
    } seq_regs_t;

endpackage

// File: rtl/mcs_len_reg.sv
module mcs_len_reg #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_VAL = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  logic [CNT_W-1:0] wdata_i,
    output logic [CNT_W-1:0] len_o
);

    localparam logic [CNT_W-1:0] LenRst = CNT_W'(RST_VAL);

    logic [CNT_W-1:0] len_d, len_q;

    always_comb begin
        len_d = len_q;
        if (we_i) begin
            len_d = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q <= LenRst;
        end else begin
            len_q <= len_d;
        end
    end

    assign len_o = len_q;

    AST_LEN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !we_i |=> $stable(len_q)); // R8

endmodule

// File: rtl/mcs_dly_cnt.sv
module mcs_dly_cnt #(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] load_val_i,
    output logic             last_o
);

    localparam logic [CNT_W-1:0] CntOne  = CNT_W'(1);
    localparam logic [CNT_W-1:0] CntZero = '0;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = load_val_i;
        end else if (cnt_q != CntZero) begin
            cnt_d = cnt_q - CntOne;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= CntZero;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign last_o = (cnt_q == CntOne);

    AST_CNT_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt_q == CntZero && !load_i) |=> (cnt_q == CntZero)); // R3

endmodule

// File: rtl/mcs_seq_fsm.sv
module mcs_seq_fsm
    import mcs_pkg::*;
#(
    parameter int unsigned CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req_i,
    input  logic             wake_req_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             cnt_last_i,
    output logic             cnt_load_o,
    output logic [CNT_W-1:0] cnt_val_o,
    output logic             pd_cmd_o,
    output logic             rec_cmd_o,
    output logic             clk_stop_o,
    output logic             clk_en_o,
    output logic             busy_o
);

    localparam logic [CNT_W-1:0] LenZero = '0;
    localparam seq_regs_t RegsRst = '{
        st:        ST_RUN,
        wake_pend: 1'b0,
        pd_cmd:    1'b0,
        rec_cmd:   1'b0,
        clk_stop:  1'b0,
        clk_en:    1'b1,
        busy:      1'b0
    };

    seq_regs_t regs_d, regs_q;

    always_comb begin
        regs_d         = regs_q;
        regs_d.pd_cmd  = 1'b0;
        regs_d.rec_cmd = 1'b0;
        cnt_load_o     = 1'b0;
        cnt_val_o      = len_i;

        unique case (regs_q.st)
            ST_RUN: begin
                regs_d.wake_pend = 1'b0;
                if (pd_req_i) begin
                    regs_d.pd_cmd = 1'b1;
                    if (len_i == LenZero) begin
                        regs_d.st       = ST_PARKED;
                        regs_d.clk_stop = 1'b1;
                    end else begin
                        regs_d.st  = ST_ENTRY;
                        cnt_load_o = 1'b1;
                    end
                end
            end
            ST_ENTRY: begin
                if (wake_req_i) begin
                    regs_d.wake_pend = 1'b1;
                end
                if (cnt_last_i) begin
                    regs_d.st       = ST_PARKED;
                    regs_d.clk_stop = 1'b1;
                end
            end
            ST_PARKED: begin
                if (wake_req_i || regs_q.wake_pend) begin
                    regs_d.wake_pend = 1'b0;
                    regs_d.clk_stop  = 1'b0;
                    if (len_i == LenZero) begin
                        regs_d.st      = ST_RUN;
                        regs_d.rec_cmd = 1'b1;
                    end else begin
                        regs_d.st  = ST_EXIT;
                        cnt_load_o = 1'b1;
                    end
                end
            end
            ST_EXIT: begin
                if (cnt_last_i) begin
                    regs_d.st      = ST_RUN;
                    regs_d.rec_cmd = 1'b1;
                end
            end
            default: begin
                regs_d = RegsRst;
            end
        endcase

        regs_d.clk_en = !regs_d.clk_stop;
        regs_d.busy   = (regs_d.st != ST_RUN) || regs_d.rec_cmd;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q <= RegsRst;
        end else begin
            regs_q <= regs_d;
        end
    end

    assign pd_cmd_o   = regs_q.pd_cmd;
    assign rec_cmd_o  = regs_q.rec_cmd;
    assign clk_stop_o = regs_q.clk_stop;
    assign clk_en_o   = regs_q.clk_en;
    assign busy_o     = regs_q.busy;

    AST_PD_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pd_cmd_o |=> !pd_cmd_o); // R2
    AST_REC_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        rec_cmd_o |=> !rec_cmd_o); // R5
    AST_PARK_GATES: assert property (@(posedge clk) disable iff (!rst_n)
        clk_stop_o |-> !clk_en_o); // R4
    AST_RUN_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        !clk_stop_o |-> clk_en_o); // R4
    AST_BUSY_SPAN: assert property (@(posedge clk) disable iff (!rst_n)
        (pd_cmd_o || rec_cmd_o || clk_stop_o) |-> busy_o); // R9
    AST_PD_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (clk_stop_o && pd_req_i) |=> !pd_cmd_o); // R10

endmodule

// File: rtl/mclk_stop_seq.sv
module mclk_stop_seq #(
    parameter int unsigned CNT_W   = 8,
    parameter int unsigned RST_LEN = 15
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             pd_req_i,
    input  logic             wake_req_i,
    input  logic             cfg_we_i,
    input  logic [CNT_W-1:0] cfg_len_i,
    output logic             pd_cmd_o,
    output logic             rec_cmd_o,
    output logic             clk_stop_o,
    output logic             clk_en_o,
    output logic             busy_o
);

    logic [CNT_W-1:0] len_w;
    logic [CNT_W-1:0] cnt_val_w;
    logic             cnt_load_w;
    logic             cnt_last_w;

    mcs_len_reg #(
        .CNT_W  (CNT_W),
        .RST_VAL(RST_LEN)
    ) u_len (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (cfg_we_i),
        .wdata_i(cfg_len_i),
        .len_o  (len_w)
    );

    mcs_dly_cnt #(
        .CNT_W(CNT_W)
    ) u_cnt (
        .clk       (clk),
        .rst_n     (rst_n),
        .load_i    (cnt_load_w),
        .load_val_i(cnt_val_w),
        .last_o    (cnt_last_w)
    );

    mcs_seq_fsm #(
        .CNT_W(CNT_W)
    ) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req_i  (pd_req_i),
        .wake_req_i(wake_req_i),
        .len_i     (len_w),
        .cnt_last_i(cnt_last_w),
        .cnt_load_o(cnt_load_w),
        .cnt_val_o (cnt_val_w),
        .pd_cmd_o  (pd_cmd_o),
        .rec_cmd_o (rec_cmd_o),
        .clk_stop_o(clk_stop_o),
        .clk_en_o  (clk_en_o),
        .busy_o    (busy_o)
    );

endmodule

// File: tb/sim_mclk_stop_seq.sv
module sim_mclk_stop_seq;

    localparam int CLK_PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pd_req_i = 1'b0;
    logic       wake_req_i = 1'b0;
    logic       cfg_we_i = 1'b0;
    logic [7:0] cfg_len_i = 8'd0;
    logic       pd_cmd_o, rec_cmd_o, clk_stop_o, clk_en_o, busy_o;

    int n_checks = 0;
    int n_errors = 0;
    int n_cycles = 0;

    // cycle model: 0 run, 1 entry, 2 parked, 3 exit
    int       m_st = 0;
    int       m_cnt = 0;
    int       m_cfg = 15;
    bit       m_pend = 1'b0;
    bit       m_pd = 1'b0, m_rec = 1'b0, m_stop = 1'b0, m_busy = 1'b0;

    mclk_stop_seq u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .pd_req_i  (pd_req_i),
        .wake_req_i(wake_req_i),
        .cfg_we_i  (cfg_we_i),
        .cfg_len_i (cfg_len_i),
        .pd_cmd_o  (pd_cmd_o),
        .rec_cmd_o (rec_cmd_o),
        .clk_stop_o(clk_stop_o),
        .clk_en_o  (clk_en_o),
        .busy_o    (busy_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        n_cycles <= n_cycles + 1;
        if (n_cycles > 150000) begin
            n_errors = n_errors + 1;
            n_checks = n_checks + 1;
            $display("FAIL watchdog: actual=%0d cycles expected=<150000", n_cycles);
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    end

    task automatic chk(input string tag, input logic act, input logic exp);
        n_checks = n_checks + 1;
        if (act !== exp) begin
            n_errors = n_errors + 1;
            $display("FAIL %s at cycle %0d: actual=%b expected=%b", tag, n_cycles, act, exp);
        end
    endtask

    function automatic bit model_busy(input int st, input bit rec);
        return (st != 0) || rec;
    endfunction

    task automatic compare_all();
        chk("R2 pd_cmd", pd_cmd_o, m_pd);
        chk("R5 rec_cmd", rec_cmd_o, m_rec);
        chk("R3 clk_stop", clk_stop_o, m_stop);
        chk("R4 clk_en", clk_en_o, !m_stop);
        chk("R9 busy", busy_o, m_busy);
    endtask

    // advance the model by one rising edge with the given inputs
    task automatic model_edge(input bit pd, input bit wk, input bit we, input int val);
        m_pd  = 1'b0;
        m_rec = 1'b0;
        case (m_st)
            0: begin
                m_pend = 1'b0;
                if (pd) begin
                    m_pd = 1'b1;
                    if (m_cfg == 0) begin m_st = 2; m_stop = 1'b1; end
                    else begin m_st = 1; m_cnt = m_cfg; end
                end
            end
            1: begin
                if (wk) m_pend = 1'b1;
                if (m_cnt == 1) begin m_st = 2; m_stop = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
            2: begin
                if (wk || m_pend) begin
                    m_pend = 1'b0;
                    m_stop = 1'b0;
                    if (m_cfg == 0) begin m_st = 0; m_rec = 1'b1; end
                    else begin m_st = 3; m_cnt = m_cfg; end
                end
            end
            default: begin
                if (m_cnt == 1) begin m_st = 0; m_rec = 1'b1; end
                else m_cnt = m_cnt - 1;
            end
        endcase
        m_busy = model_busy(m_st, m_rec);
        if (we) m_cfg = val;
    endtask

    // called at a falling edge: check, drive, advance one cycle
    task automatic step(input bit pd, input bit wk, input bit we, input int val);
        compare_all();
        pd_req_i   = pd;
        wake_req_i = wk;
        cfg_we_i   = we;
        cfg_len_i  = 8'(val);
        model_edge(pd, wk, we, val);
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 1'b0, 0);
    endtask

    initial begin
        int gap;
        void'($urandom(32'd20250611));
        repeat (3) @(negedge clk);
        // R1: outputs during reset
        chk("R1 clk_en in reset", clk_en_o, 1'b1);
        chk("R1 clk_stop in reset", clk_stop_o, 1'b0);
        chk("R1 busy in reset", busy_o, 1'b0);
        rst_n = 1'b1;
        chk("R1 pd_cmd after reset", pd_cmd_o, 1'b0);
        chk("R1 rec_cmd after reset", rec_cmd_o, 1'b0);

        // R7: default count of 15 measured at the ports
        step(1'b1, 1'b0, 1'b0, 0);
        gap = 0;
        while (!clk_stop_o && gap < 300) begin
            step(1'b0, 1'b0, 1'b0, 0);
            gap++;
        end
        n_checks++;
        if (gap != 15) begin
            n_errors++;
            $display("FAIL R7 reset count: actual=%0d expected=15", gap);
        end
        // R10: power-down request while parked is ignored
        step(1'b1, 1'b0, 1'b0, 0);
        chk("R10 pd ignored parked", pd_cmd_o, 1'b0);
        step(1'b0, 1'b1, 1'b0, 0);
        idle(20);

        // R3/R5: zero count
        step(1'b0, 1'b0, 1'b1, 0);
        step(1'b1, 1'b0, 1'b0, 0);
        idle(2);
        step(1'b0, 1'b1, 1'b0, 0);
        idle(3);

        // R6/R8: wake during entry, count rewritten mid-sequence
        step(1'b0, 1'b0, 1'b1, 6);
        step(1'b1, 1'b0, 1'b1, 2);
        step(1'b0, 1'b1, 1'b1, 3);
        idle(20);

        // R7: full-scale count of 255
        step(1'b0, 1'b0, 1'b1, 255);
        step(1'b1, 1'b0, 1'b0, 0);
        idle(260);
        step(1'b0, 1'b1, 1'b0, 0);
        idle(260);

        // R10: both requests together while running, wake while running
        step(1'b0, 1'b0, 1'b1, 1);
        step(1'b0, 1'b1, 1'b0, 0);
        step(1'b1, 1'b1, 1'b0, 0);
        idle(5);

        // constrained random
        for (int i = 0; i < 5000; i++) begin
            bit pd, wk, we;
            int v;
            pd = ($urandom_range(0, 5) == 0);
            wk = ($urandom_range(0, 5) == 0);
            we = ($urandom_range(0, 7) == 0);
            v  = ($urandom_range(0, 19) == 0) ? int'($urandom_range(0, 255))
                                               : int'($urandom_range(0, 4));
            step(pd, wk, we, v);
        end
        compare_all();

        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule